// File: doc/BRIEF.md
# Programmable Seconds-Pulse Delay Generator

This block takes a once-per-second master pulse and produces a copy of it that is delayed by a programmable amount between 0 and 999,999 microseconds. The delay is dialled in as six BCD digits. It runs from a 10 MHz system clock and takes a one-cycle 1 MHz enable as its microsecond time base.

Each rising edge of the master pulse starts a fixed sequence. First a clear phase empties a six-decade BCD counter. Next a load phase copies the nines complement of the dial setting into it. During both phases counting is held off. After that the counter advances on every 1 MHz enable until all six decades read 9. At that point it stops, and a one-microsecond gate window opens. The first 1 MHz enable inside the window fires a short output pulse. The block then sits idle until the next master edge. The sub-microsecond fine delay and any output drivers sit outside this block. All pins are plain control and status; there is no streamed data path.

Top module: `pps_preset_delay`

## Requirements
- R1: With dial value D (digit i on `dial_bcd[4i+3:4i]`, digit 0 least significant), the output fires on the (D+1)th 1 MHz enable counted from the first enable sampled 19 or more clock edges after the edge that saw the master rise.
- R2: The clock edge that sees `pps_in` go from 0 to 1 starts a clear phase 13 clocks long that holds the counter at zero. `busy` is high from the cycle after that edge.
- R3: The clear phase is followed by a load phase 5 clocks long that places the nines complement of each dial digit in the counter.
- R4: Enables that arrive during the 18 clocks of the clear and load phases are not counted.
- R5: After the load phase the counter steps by exactly one per 1 MHz enable, in BCD, and holds when there is no enable.
- R6: Once every decade holds 9, `gate_win` is high for at most 10 clocks. The output pulse only starts from inside that window.
- R7: An enable inside the gate window drives `pps_out` high for exactly 2 clocks, starting in the cycle after that edge.
- R8: After the output pulse, the counter stops and `busy` is low. No further pulse appears until the next master rise.
- R9: A dial digit above 9 is loaded as if it were 9.
- R10: A master rise arriving in any phase abandons the running sequence and restarts from the clear phase.
- R11: The dial is read only during the load phase. A change after that phase does not alter the delay in progress.
- R12: Holding `pps_in` high does not retrigger. During and right after reset, `pps_out`, `gate_win` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1m | input | 1 | One-cycle 1 MHz enable |
| pps_in | input | 1 | Master once-per-second pulse; its rising edge starts a sequence |
| dial_bcd | input | 24 | Six BCD delay digits, in microseconds |
| pps_out | output | 1 | Delayed pulse, 2 clocks wide |
| gate_win | output | 1 | High while the all-nines gate window is open |
| busy | output | 1 | High from the master rise until the output fires or the window expires |

## Verification
The hardest cases are the ones where the master rise lands at a chosen position relative to the 1 MHz enable. This covers the edge of the hold-off, a rise that interrupts a long count, and a dial change after the load phase. The bench generates the enable itself and raises `pps_in` on the same edge as an enable. This fixes which enables fall inside the 18-clock hold-off. It then counts enables at the ports from edge 19 onward. Restarts and late dial changes are injected at fixed edge offsets within that same frame.

// File: rtl/ppsd_pkg.sv
package ppsd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_LOAD,
    PH_COUNT,
    PH_GATE
  } phase_e;

  // clamp a digit to 9, then take its nines complement
  function automatic logic [3:0] nines_comp(input logic [3:0] d);
    logic [3:0] c;
    c = (d > 4'd9) ? 4'd9 : d;
    return 4'd9 - c;
  endfunction

endpackage

// File: rtl/ppsd_decade.sv
module ppsd_decade (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [3:0] load_val,
  input  logic       step,
  output logic [3:0] q,
  output logic       is_nine
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 4'd0;
    else if (clr)   q <= 4'd0;
    else if (load)  q <= load_val;
    else if (step)  q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
  end

  assign is_nine = (q == 4'd9);

  // R9: a clamped load never leaves a non-decimal code in a decade
  a_r9_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    q <= 4'd9);

endmodule

// File: rtl/ppsd_chain.sv
module ppsd_chain #(
  parameter int NUM_DIGITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic                    step,
  input  logic [4*NUM_DIGITS-1:0] dial,
  output logic [4*NUM_DIGITS-1:0] count,
  output logic                    all_nines
);
  import ppsd_pkg::*;

  logic [NUM_DIGITS-1:0] nine;
  logic [NUM_DIGITS-1:0] carry;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    if (i == 0) begin : g_lsd
      assign carry[i] = step;
    end else begin : g_upper
      assign carry[i] = carry[i-1] & nine[i-1];
    end

    ppsd_decade u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (load),
      .load_val (nines_comp(dial[4*i +: 4])),
      .step     (carry[i]),
      .q        (count[4*i +: 4]),
      .is_nine  (nine[i])
    );
  end

  assign all_nines = &nine;

endmodule

// File: rtl/ppsd_seq.sv
module ppsd_seq #(
  parameter int CLEAR_CYC = 13,
  parameter int LOAD_CYC  = 5,
  parameter int GATE_CYC  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise,
  input  logic            tick,
  input  logic            all_nines,
  output ppsd_pkg::phase_e phase,
  output logic            clr,
  output logic            load,
  output logic            cnt_en,
  output logic            fire
);
  import ppsd_pkg::*;

  localparam int TMAX = (CLEAR_CYC > LOAD_CYC)
                        ? ((CLEAR_CYC > GATE_CYC) ? CLEAR_CYC : GATE_CYC)
                        : ((LOAD_CYC > GATE_CYC) ? LOAD_CYC : GATE_CYC);
  localparam int TW = $clog2(TMAX + 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tmr   <= '0;
    end else if (rise) begin
      phase <= PH_CLEAR;
      tmr   <= '0;
    end else begin
      unique case (phase)
        PH_CLEAR: begin
          if (tmr == TW'(CLEAR_CYC - 1)) begin
            phase <= PH_LOAD;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PH_LOAD: begin
          if (tmr == TW'(LOAD_CYC - 1)) begin
            phase <= PH_COUNT;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PH_COUNT: begin
          if (all_nines) begin
            phase <= PH_GATE;
            tmr   <= '0;
          end
        end
        PH_GATE: begin
          if (tick || tmr == TW'(GATE_CYC - 1)) begin
            phase <= PH_IDLE;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          tmr   <= '0;
        end
      endcase
    end
  end

  assign clr    = (phase == PH_CLEAR);
  assign load   = (phase == PH_LOAD);
  assign cnt_en = (phase == PH_COUNT) && tick && !all_nines;
  assign fire   = (phase == PH_GATE) && tick;

  // R10: a master rise always lands in the clear phase
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> phase == PH_CLEAR);

  // R3: the load phase only follows a completed clear phase
  a_r3_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && $past(phase) != PH_LOAD) |-> $past(phase) == PH_CLEAR);

endmodule

// File: rtl/ppsd_pulse.sv
module ppsd_pulse #(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (fire)       left <= PW'(PULSE_CYC);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pulse = (left != '0);

endmodule

// File: rtl/pps_preset_delay.sv
module pps_preset_delay #(
  parameter int NUM_DIGITS = 6,
  parameter int CLEAR_CYC  = 13,
  parameter int LOAD_CYC   = 5,
  parameter int GATE_CYC   = 10,
  parameter int PULSE_CYC  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_1m,
  input  logic                    pps_in,
  input  logic [4*NUM_DIGITS-1:0] dial_bcd,
  output logic                    pps_out,
  output logic                    gate_win,
  output logic                    busy
);
  import ppsd_pkg::*;

  localparam int CW = 4 * NUM_DIGITS;

  logic            pps_q;
  logic            rise;
  phase_e          phase;
  logic            clr, load, cnt_en, fire;
  logic [CW-1:0]   count;
  logic            all_nines;

  always_ff @(posedge clk) begin
    if (!rst_n) pps_q <= 1'b0;
    else        pps_q <= pps_in;
  end

  assign rise = pps_in & ~pps_q;

  ppsd_seq #(
    .CLEAR_CYC (CLEAR_CYC),
    .LOAD_CYC  (LOAD_CYC),
    .GATE_CYC  (GATE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .tick      (tick_1m),
    .all_nines (all_nines),
    .phase     (phase),
    .clr       (clr),
    .load      (load),
    .cnt_en    (cnt_en),
    .fire      (fire)
  );

  ppsd_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .load      (load),
    .step      (cnt_en),
    .dial      (dial_bcd),
    .count     (count),
    .all_nines (all_nines)
  );

  ppsd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (pps_out)
  );

  assign gate_win = (phase == PH_GATE);
  assign busy     = (phase != PH_IDLE);

  // R2: the counter reads zero once the clear phase has run a cycle
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLEAR && $past(phase) == PH_CLEAR) |-> count == '0);

  // R5: no enable, no step while counting
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COUNT && !tick_1m && !rise) |=> $stable(count));

  // R6: the output pulse is launched only from the gate window
  a_r6_from_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_out) |-> $past(gate_win));

  // R7: pulse width of two clocks
  a_r7_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_out) |=> pps_out);
  a_r7_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_out && $past(pps_out)) |=> !pps_out);

  // R8: idle stays idle without a new rise
  a_r8_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !rise) |=> phase == PH_IDLE);

endmodule

// File: tb/tb_pps_preset_delay.sv
`timescale 1ns/1ps
module tb_pps_preset_delay;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1m = 1'b0;
  logic        pps_in = 1'b0;
  logic [23:0] dial_bcd = '0;
  logic        pps_out, gate_win, busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int ph = 0;
  bit arm = 1'b0;
  bit drop = 1'b0;

  always #5 clk = ~clk;

  pps_preset_delay dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1m  (tick_1m),
    .pps_in   (pps_in),
    .dial_bcd (dial_bcd),
    .pps_out  (pps_out),
    .gate_win (gate_win),
    .busy     (busy)
  );

  // 1 MHz enable and master pulse, driven away from the active edge
  always @(negedge clk) begin
    ph = (ph == 9) ? 0 : ph + 1;
    tick_1m = (ph == 9);
    if (drop) begin
      pps_in = 1'b0;
      drop = 1'b0;
    end else if (arm && ph == 9) begin
      pps_in = 1'b1;
      arm = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog R1: act %0d cycles, exp below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  // raise pps_in on an enable edge, count enables from edge 19 until pps_out
  task automatic run_case(input logic [23:0] d, input int exp_ticks, input string req,
                          input bit late, input logic [23:0] late_d);
    int ticks = 0;
    bit seen = 0;
    int w = 1;
    dial_bcd = d;
    drop = 1'b1;
    repeat (3) @(posedge clk);
    arm = 1'b1;
    wait (pps_in == 1'b1);
    for (int i = 0; i < 15000 && !seen; i++) begin
      @(posedge clk); #1;
      if (i == 0) chk(busy == 1'b1, "R2", "busy after rise", busy, 1);
      if (late && i == 40) dial_bcd = late_d;
      if (i >= 19 && tick_1m) ticks++;
      if (pps_out) seen = 1;
    end
    chk(seen, req, "pulse seen", seen, 1);
    chk(ticks == exp_ticks, req, "enables to fire", ticks, exp_ticks);
    chk(busy == 1'b0, "R8", "busy after fire", busy, 0);
    for (int j = 0; j < 10; j++) begin
      @(posedge clk); #1;
      if (pps_out) w++;
      else break;
    end
    chk(w == 2, "R7", "pulse width", w, 2);
  endtask

  localparam int NV = 10;
  localparam logic [23:0] VD [0:NV-1] = '{
    24'h000000, 24'h000001, 24'h000007, 24'h000009, 24'h000010,
    24'h000042, 24'h00000F, 24'h0000AB, 24'h000123, 24'h001000 };
  localparam int VE [0:NV-1] = '{ 1, 2, 8, 10, 11, 43, 10, 100, 124, 1001 };

  initial begin
    // R12: outputs low in and right after reset
    repeat (4) @(posedge clk);
    #1;
    chk(pps_out == 0 && gate_win == 0 && busy == 0, "R12", "outputs in reset",
        {pps_out, gate_win, busy}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(pps_out == 0 && gate_win == 0 && busy == 0, "R12", "outputs after reset",
        {pps_out, gate_win, busy}, 0);

    // R1, R4, R5 (and R9 on entries 6 and 7): table walk
    for (int v = 0; v < NV; v++)
      run_case(VD[v], VE[v], (v == 6 || v == 7) ? "R9" : "R1", 1'b0, 24'h0);

    // R8, R12: pps_in stays high, nothing more happens
    begin
      bit quiet = 1;
      for (int i = 0; i < 1500; i++) begin
        @(posedge clk); #1;
        if (pps_out || busy || gate_win) quiet = 0;
      end
      chk(quiet, "R8", "no retrigger while pps_in held high", quiet, 1);
    end

    // R10: interrupt a long count with a new master rise
    dial_bcd = 24'h000500;
    drop = 1'b1;
    repeat (3) @(posedge clk);
    arm = 1'b1;
    wait (pps_in == 1'b1);
    repeat (200) @(posedge clk);
    run_case(24'h000003, 4, "R10", 1'b0, 24'h0);
    begin
      bit quiet = 1;
      for (int i = 0; i < 6000; i++) begin
        @(posedge clk); #1;
        if (pps_out) quiet = 0;
      end
      chk(quiet, "R10", "abandoned sequence stays silent", quiet, 1);
    end

    // R11: dial change after the load phase is ignored
    run_case(24'h000020, 21, "R11", 1'b1, 24'h000090);

    // R3: a load of the full complement, dial 0 fires on first enable past hold-off
    run_case(24'h000000, 1, "R3", 1'b0, 24'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule